// File: doc/BRIEF.md
# In-Cache Atomic Read-Modify-Write Unit

This block sits beside a core's private first-level data cache and carries out atomic read-modify-write operations on 32-bit words inside that cache. Memory is not asked to do the update, and the core does not split the operation into a separate load and store. The core hands over one request carrying a word address, an operand and a 4-bit operation code. The unit then gets the target word with exclusive ownership. If the word is already held, no memory traffic is needed. If it is not held, the unit sends an exclusive read to a simple shared-memory port, first writing back any modified word that occupies the slot. The update is computed locally, the new value is stored in the cached line, and the value the word held before the update goes back to the core.

The cache is direct-mapped with one word per line. Every line the unit fills is held exclusively and is modified at once, so it is always dirty and is written back when a conflicting address displaces it. Only one operation is in flight at a time, and the request side stays closed until the core has taken the response.

Top module: `l1_amo_unit`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0 and mem_req_valid is 0, and no line is present, so the first operation to any address misses.
- R2: A request is taken at a rising edge where req_valid and req_ready are both 1. From that edge until the edge that completes the response handshake (rsp_valid and rsp_ready both 1), req_ready stays 0.
- R3: On a miss the unit issues a read-exclusive request (mem_req_write = 0) at the requested word address. It then waits for mem_rsp_valid and returns the data sampled with mem_rsp_valid as the old value.
- R4: On a hit, rsp_valid is 1 at the first rising edge after the accepting edge, and no memory request is raised.
- R5: The operation codes are 0 swap, 1 add (wrapping modulo 2^32), 2 and, 3 or, 4 xor, 5 signed minimum, 6 signed maximum, 7 unsigned minimum and 8 unsigned maximum. The minimum and maximum operations compare the old word with the operand, and 0x80000000 is the smallest signed value.
- R6: Operation codes 9 to 15 return the old value and leave the word unchanged.
- R7: The updated word is written into the line in the same cycle the response is raised, so the next operation on the same address sees it as its old value.
- R8: A miss whose slot holds another address first writes that word back (mem_req_write = 1) at its own word address with its latest value, and only then issues the exclusive read.
- R9: While rsp_valid is 1 and rsp_ready is 0, rsp_valid stays 1 and rsp_old does not change.
- R10: While mem_req_valid is 1 and mem_req_ready is 0, mem_req_valid stays 1 and mem_req_write, mem_req_addr and mem_req_wdata do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core presents an atomic request |
| req_ready | output | 1 | Unit can take a request |
| req_addr | input | ADDR_W | Word address of the target |
| req_op | input | 4 | Operation code |
| req_operand | input | WORD_W | Operand of the update |
| rsp_valid | output | 1 | Old value is available |
| rsp_ready | input | 1 | Core takes the response |
| rsp_old | output | WORD_W | Value the word held before the update |
| mem_req_valid | output | 1 | Request to shared memory |
| mem_req_ready | input | 1 | Shared memory takes the request |
| mem_req_write | output | 1 | 1 write-back, 0 exclusive read |
| mem_req_addr | output | ADDR_W | Word address of the memory request |
| mem_req_wdata | output | WORD_W | Write-back data |
| mem_rsp_valid | input | 1 | Read data returned from memory |
| mem_rsp_data | input | WORD_W | Read data |

## Verification
The hardest case to reach is a dirty word written back while the core's response path and the memory port are both stalling. The evicted value must be the one left by the last update, and a later re-fetch has to return it through memory. The bench reaches this by aiming operations at addresses that share a slot, such as A and A plus the line count, after chains of updates on A. The memory model varies its grant and data delays, and the response side withholds ready in a repeating pattern. A scoreboard of old values, kept from a reference word image, then shows whether the value that went out to memory came back intact.

// File: rtl/amo_pkg.sv
package amo_pkg;
  typedef enum logic [3:0] {
    OP_SWAP = 4'd0,
    OP_ADD  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_MIN  = 4'd5,
    OP_MAX  = 4'd6,
    OP_MINU = 4'd7,
    OP_MAXU = 4'd8
  } amo_op_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_LOOKUP = 3'd1,
    ST_WBACK  = 3'd2,
    ST_FETCH  = 3'd3,
    ST_WAIT   = 3'd4,
    ST_RESP   = 3'd5
  } amo_state_e;
endpackage

// File: rtl/amo_alu.sv
module amo_alu #(
  parameter int W = 32
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] old_val,
  input  logic [W-1:0] operand,
  output logic [W-1:0] new_val
);
  import amo_pkg::*;

  logic lt_s, lt_u;

  always_comb begin
    lt_s = $signed(old_val) < $signed(operand);
    lt_u = old_val < operand;
    case (op)
      OP_SWAP: new_val = operand;
      OP_ADD:  new_val = old_val + operand;
      OP_AND:  new_val = old_val & operand;
      OP_OR:   new_val = old_val | operand;
      OP_XOR:  new_val = old_val ^ operand;
      OP_MIN:  new_val = lt_s ? old_val : operand;
      OP_MAX:  new_val = lt_s ? operand : old_val;
      OP_MINU: new_val = lt_u ? old_val : operand;
      OP_MAXU: new_val = lt_u ? operand : old_val;
      default: new_val = old_val;
    endcase
  end
endmodule

// File: rtl/amo_line_store.sv
module amo_line_store #(
  parameter int NUM_LINES = 8,
  parameter int TAG_W     = 13,
  parameter int W         = 32,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [W-1:0]     rd_data,
  input  logic [IDX_W-1:0] lk_idx,
  output logic             lk_valid,
  output logic             lk_dirty,
  output logic [TAG_W-1:0] lk_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [W-1:0]     wr_data
);
  logic [W-1:0]     data_mem [NUM_LINES];
  logic [TAG_W-1:0] tag_mem  [NUM_LINES];
  logic [NUM_LINES-1:0] valid_q, dirty_q;

  // Data array: synchronous read and write, no reset, suited to block RAM.
  always_ff @(posedge clk) begin
    if (wr_en) data_mem[wr_idx] <= wr_data;
    if (rd_en) rd_data <= data_mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_idx] <= wr_tag;
  end

  genvar g;
  generate
    for (g = 0; g < NUM_LINES; g++) begin : g_meta
      always_ff @(posedge clk) begin
        if (rst) begin
          valid_q[g] <= 1'b0;
          dirty_q[g] <= 1'b0;
        end else if (wr_en && wr_idx == IDX_W'(g)) begin
          valid_q[g] <= 1'b1;
          dirty_q[g] <= 1'b1;
        end
      end
    end
  endgenerate

  assign lk_valid = valid_q[lk_idx];
  assign lk_dirty = dirty_q[lk_idx];
  assign lk_tag   = tag_mem[lk_idx];
endmodule

// File: rtl/l1_amo_unit.sv
module l1_amo_unit #(
  parameter int ADDR_W    = 16,
  parameter int NUM_LINES = 8,
  parameter int WORD_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_op,
  input  logic [WORD_W-1:0] req_operand,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_old,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [WORD_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data
);
  import amo_pkg::*;

  localparam int IDX_W = $clog2(NUM_LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  amo_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [3:0]        op_q;
  logic [WORD_W-1:0] opnd_q;
  logic [WORD_W-1:0] old_q;

  logic              accept;
  logic [WORD_W-1:0] rd_data, alu_old, alu_new;
  logic              lk_valid, lk_dirty, hit;
  logic [TAG_W-1:0]  lk_tag;
  logic              wr_en;

  assign accept  = req_valid && req_ready;
  assign hit     = lk_valid && (lk_tag == addr_q[ADDR_W-1:IDX_W]);
  assign alu_old = (state_q == ST_LOOKUP) ? rd_data : mem_rsp_data;
  assign wr_en   = (state_q == ST_LOOKUP && hit) ||
                   (state_q == ST_WAIT && mem_rsp_valid);

  amo_line_store #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W), .W(WORD_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (accept),
    .rd_idx   (req_addr[IDX_W-1:0]),
    .rd_data  (rd_data),
    .lk_idx   (addr_q[IDX_W-1:0]),
    .lk_valid (lk_valid),
    .lk_dirty (lk_dirty),
    .lk_tag   (lk_tag),
    .wr_en    (wr_en),
    .wr_idx   (addr_q[IDX_W-1:0]),
    .wr_tag   (addr_q[ADDR_W-1:IDX_W]),
    .wr_data  (alu_new)
  );

  amo_alu #(.W(WORD_W)) u_alu (
    .op      (op_q),
    .old_val (alu_old),
    .operand (opnd_q),
    .new_val (alu_new)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      op_q    <= '0;
      opnd_q  <= '0;
      old_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          addr_q  <= req_addr;
          op_q    <= req_op;
          opnd_q  <= req_operand;
          state_q <= ST_LOOKUP;
        end
        ST_LOOKUP: begin
          if (hit) begin
            old_q   <= rd_data;
            state_q <= ST_RESP;
          end else if (lk_valid && lk_dirty) begin
            state_q <= ST_WBACK;
          end else begin
            state_q <= ST_FETCH;
          end
        end
        ST_WBACK: if (mem_req_ready) state_q <= ST_FETCH;
        ST_FETCH: if (mem_req_ready) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          old_q   <= mem_rsp_data;
          state_q <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign rsp_valid     = (state_q == ST_RESP);
  assign rsp_old       = old_q;
  assign mem_req_valid = (state_q == ST_WBACK) || (state_q == ST_FETCH);
  assign mem_req_write = (state_q == ST_WBACK);
  assign mem_req_addr  = (state_q == ST_WBACK) ? {lk_tag, addr_q[IDX_W-1:0]} : addr_q;
  assign mem_req_wdata = rd_data;

  // R2
  accept_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_ready);

  // R4
  hit_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOOKUP && hit) |=> rsp_valid && !mem_req_valid);

  // R8
  wb_then_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && mem_req_ready && mem_req_write |=> mem_req_valid && !mem_req_write);

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_old));

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_write)
      && $stable(mem_req_addr) && $stable(mem_req_wdata));
endmodule

// File: tb/l1_amo_unit_tb.sv
module l1_amo_unit_tb;
  localparam int ADDR_W = 16;
  localparam int NLINES = 8;
  localparam int IDX_W  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [3:0] req_op = '0;
  logic [31:0] req_operand = '0;
  logic rsp_valid, rsp_ready = 1'b0;
  logic [31:0] rsp_old;
  logic mem_req_valid, mem_req_ready = 1'b0, mem_req_write;
  logic [ADDR_W-1:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  always #5 clk = ~clk;

  l1_amo_unit #(.ADDR_W(ADDR_W), .NUM_LINES(NLINES), .WORD_W(32)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_op(req_op), .req_operand(req_operand),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_old(rsp_old),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  int errors = 0;
  int checks = 0;
  logic [31:0] exp_q[$];
  logic [31:0] golden [logic [ADDR_W-1:0]];
  logic [31:0] backing [logic [ADDR_W-1:0]];
  logic [ADDR_W-IDX_W-1:0] tag_m [NLINES];
  logic [NLINES-1:0] val_m = '0;
  logic exp_wb;
  logic [ADDR_W-1:0] exp_wb_addr, exp_fetch_addr;
  int lat_cnt = 0;
  int rdy_cnt = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] init_word(input logic [ADDR_W-1:0] a);
    return ({16'h0, a} * 32'h9E3779B1) ^ 32'h1234ABCD;
  endfunction

  function automatic logic [31:0] gold_get(input logic [ADDR_W-1:0] a);
    if (golden.exists(a)) return golden[a];
    return init_word(a);
  endfunction

  function automatic logic [31:0] mem_get(input logic [ADDR_W-1:0] a);
    if (backing.exists(a)) return backing[a];
    return init_word(a);
  endfunction

  function automatic logic [31:0] ref_alu(input logic [3:0] op, input logic [31:0] o, input logic [31:0] b);
    case (op)
      4'd0: return b;
      4'd1: return o + b;
      4'd2: return o & b;
      4'd3: return o | b;
      4'd4: return o ^ b;
      4'd5: return ($signed(o) < $signed(b)) ? o : b;
      4'd6: return ($signed(o) > $signed(b)) ? o : b;
      4'd7: return (o < b) ? o : b;
      4'd8: return (o > b) ? o : b;
      default: return o;
    endcase
  endfunction

  // Driver: pushes the expected old value and checks the hit/miss path timing.
  task automatic amo(input logic [ADDR_W-1:0] a, input logic [3:0] op, input logic [31:0] opnd);
    logic [IDX_W-1:0] idx;
    logic hit;
    logic [31:0] old;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    idx = a[IDX_W-1:0];
    hit = val_m[idx] && tag_m[idx] == a[ADDR_W-1:IDX_W];
    exp_wb = !hit && val_m[idx];
    exp_wb_addr = {tag_m[idx], idx};
    exp_fetch_addr = a;
    old = gold_get(a);
    exp_q.push_back(old);
    golden[a] = ref_alu(op, old, opnd);
    req_valid = 1'b1; req_addr = a; req_op = op; req_operand = opnd;
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R2 req_ready low after accept", {31'b0, req_ready}, 32'd0);
    @(negedge clk);
    if (hit) begin
      check(rsp_valid && !mem_req_valid, "R4 hit response next cycle",
            {30'b0, rsp_valid, mem_req_valid}, 32'd2);
    end else begin
      check(mem_req_valid && !rsp_valid, "R3 miss raises memory request",
            {30'b0, mem_req_valid, rsp_valid}, 32'd2);
      check(mem_req_write == exp_wb, "R8 write-back first when slot occupied",
            {31'b0, mem_req_write}, {31'b0, exp_wb});
    end
    val_m[idx] = 1'b1;
    tag_m[idx] = a[ADDR_W-1:IDX_W];
  endtask

  // Monitor: response side with a stall pattern; compares against the queue.
  initial begin
    logic prev_stall = 1'b0;
    logic [31:0] prev_old = '0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (prev_stall)
          check(rsp_valid && rsp_old == prev_old, "R9 response held while stalled",
                rsp_old, prev_old);
        rdy_cnt++;
        rsp_ready = (rdy_cnt % 4) != 1;
        if (rsp_valid && rsp_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R2 unexpected response", rsp_old, 32'hx);
          end else begin
            logic [31:0] e;
            e = exp_q.pop_front();
            check(rsp_old == e, "R5 R6 R7 old value", rsp_old, e);
          end
        end
        prev_stall = rsp_valid && !rsp_ready;
        prev_old = rsp_old;
      end
    end
  end

  // Shared-memory model with varying grant and data delays.
  initial begin
    forever begin
      @(negedge clk);
      mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b0;
      if (!rst && mem_req_valid) begin
        logic w;
        logic [ADDR_W-1:0] ad;
        logic [31:0] wd;
        w = mem_req_write; ad = mem_req_addr; wd = mem_req_wdata;
        lat_cnt++;
        repeat (lat_cnt % 3) begin
          @(negedge clk);
          check(mem_req_valid && mem_req_write == w && mem_req_addr == ad && mem_req_wdata == wd,
                "R10 memory request held", {16'b0, mem_req_addr}, {16'b0, ad});
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        if (w) begin
          check({16'b0, ad} == {16'b0, exp_wb_addr}, "R8 write-back address",
                {16'b0, ad}, {16'b0, exp_wb_addr});
          check(wd == gold_get(ad), "R8 write-back data", wd, gold_get(ad));
          backing[ad] = wd;
        end else begin
          check(ad == exp_fetch_addr, "R3 exclusive read address",
                {16'b0, ad}, {16'b0, exp_fetch_addr});
          repeat ((lat_cnt + 1) % 3) @(negedge clk);
          mem_rsp_valid = 1'b1;
          mem_rsp_data = mem_get(ad);
          @(negedge clk);
          mem_rsp_valid = 1'b0;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rs;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(req_ready && !rsp_valid && !mem_req_valid, "R1 reset state",
          {29'b0, req_ready, rsp_valid, mem_req_valid}, 32'd4);

    // R5 operation set with boundaries, chained on one address (hits after the first miss).
    amo(16'h0010, 4'd0, 32'h7FFFFFFF);
    amo(16'h0010, 4'd5, 32'h80000000);
    amo(16'h0010, 4'd8, 32'h00000001);
    amo(16'h0010, 4'd6, 32'h00000001);
    amo(16'h0010, 4'd7, 32'hFFFFFFFF);
    amo(16'h0010, 4'd1, 32'hFFFFFFFF);
    amo(16'h0010, 4'd3, 32'hF0F0000F);
    amo(16'h0010, 4'd2, 32'h0FF0FFFF);
    amo(16'h0010, 4'd4, 32'hFFFFFFFF);
    amo(16'h0010, 4'd5, 32'h00000003);
    amo(16'h0010, 4'd8, 32'hFFFFFFFE);
    // R6 undefined codes leave the word unchanged
    amo(16'h0010, 4'd12, 32'h0BADF00D);
    amo(16'h0010, 4'd15, 32'h0BADF00D);
    amo(16'h0010, 4'd0, 32'h00000055);
    // R8 conflicting address evicts dirty word; R7 re-fetch returns it
    amo(16'h0018, 4'd1, 32'h00000001);
    amo(16'h0010, 4'd0, 32'h12345678);
    amo(16'h0018, 4'd0, 32'h0);

    rs = 32'hACE1_1234;
    for (int i = 0; i < 300; i++) begin
      logic [ADDR_W-1:0] a;
      rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
      a = {11'b0, rs[4:0]} + 16'h0100 * {14'b0, rs[9:8]};
      amo(a, rs[13:10] % 4'd10 + (rs[14] ? 4'd0 : 4'd0), {rs[31:16], rs[15:0] ^ 16'h5A5A});
    end

    @(negedge clk);
    while (!req_ready || exp_q.size() != 0) @(negedge clk);
    check(exp_q.size() == 0, "R2 all responses delivered", exp_q.size(), 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule